// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counter for operating-system time bases. A 24-bit counter is loaded from a reload register and decremented once per tick. A tick is either every core clock cycle or each cycle on which a one-cycle reference strobe, synchronous to the core clock, is high. When the counter is at zero and one more tick arrives, the count expires. Expiry reloads the counter, sets a sticky count flag and, if enabled, raises a one-cycle interrupt request.

Software reaches the block through a 32-bit register port with four word registers:

- offset 0x0: control and status.
- offset 0x4: reload value.
- offset 0x8: current counter value.
- offset 0xC: fixed calibration word.

The state machine has two states, `ST_OFF` and `ST_RUN`:

- **start**: `ST_OFF` to `ST_RUN`, on a control write that sets the enable bit. It loads the reload value.
- **stop**: `ST_RUN` to `ST_OFF`, on a control write that clears the enable bit.
- **last**: `ST_RUN` to `ST_OFF`, on an expiry while the reload value is zero.
- **wrap**: `ST_RUN` to `ST_RUN`, on an expiry with a non-zero reload value. It reloads the counter.
- **force**: stays in the same state. It reloads the counter on a write to the current-value register, or on a change of clock source while running.
- **step**: `ST_RUN` to `ST_RUN`, a plain decrement on a tick.

Top module: `tick_timer`

## Requirements
- R1: After reset the following hold: control reads 0, reload reads 0, current reads 0, calibration reads 10000, and `irq_pulse` is low.
- R2: Control register fields are bit 0 enable, bit 1 interrupt enable, bit 2 clock source (1 = core clock, 0 = reference strobe) and bit 16 count flag. Only bits 2:0 are writable, and all other bits read 0.
- R3: Setting enable while stopped loads the reload value into the counter. The counter then decrements on each tick, so expiries are reload+1 ticks apart.
- R4: With clock source 0 the counter changes only on cycles where `ext_tick` is high. With clock source 1 it counts every cycle.
- R5: On expiry the count flag is set. `irq_pulse` is high for exactly the one cycle after the expiry edge, and only if interrupt enable was set.
- R6: A read of the control register returns the flag and then clears it. An expiry in the same cycle leaves the flag set.
- R7: An expiry with a reload value of zero clears the enable bit and counting stops.
- R8: Any write to the current register reloads the counter and clears the flag. The written data is ignored.
- R9: The current register reads 0 while enable is clear.
- R10: The calibration register always reads 10000. Writes to it have no effect.
- R11: Writing a different clock source while enabled reloads the counter.
- R12: Clearing enable stops counting, with no further expiries. Enabling again reloads the counter from the reload value.
- R13: The reload register keeps 24 bits. Written bits 31:24 are dropped, and reads are zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | One-cycle reference tick strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flag on control read) |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt request on expiry |

## Verification
The hardest case to reach is a control read that lands in exactly the cycle in which the counter expires. The read must not swallow the new flag. The bench sets a short period on the core clock and reads the control register every cycle for several periods, so reads fall on every phase of the count, expiry included. A behavioural model checked on every clock catches any lost or stale flag. The reference-strobe mode is driven with an irregular strobe pattern, and a clock-source change is made mid-count, so that both the forced reload and the stalls between strobes are observed.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } tmr_state_e;

    // control register bit positions
    localparam int BIT_EN   = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;

    // word index of each register (byte offset / 4)
    localparam int IDX_CTRL = 0;
    localparam int IDX_RLD  = 1;
    localparam int IDX_CUR  = 2;
    localparam int IDX_CAL  = 3;

endpackage

// File: rtl/tick_timer_src.sv
module tick_timer_src (
    input  logic use_core,
    input  logic ext_tick,
    output logic tick
);
    assign tick = use_core ? 1'b1 : ext_tick;
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             cmd_force,
    input  logic [CNT_W-1:0] reload_val,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (cmd_start) begin            // start
                    state_d = ST_RUN;
                    cnt_d   = reload_val;
                end else if (cmd_force) begin   // force
                    cnt_d = reload_val;
                end
            end
            ST_RUN: begin
                if (cmd_stop) begin             // stop
                    state_d = ST_OFF;
                end else if (cmd_force) begin   // force
                    cnt_d = reload_val;
                end else if (tick) begin
                    if (cnt_q == '0) begin
                        expire = 1'b1;
                        cnt_d  = reload_val;     // wrap
                        if (reload_val == '0) begin
                            state_d = ST_OFF;    // last
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;    // step
                    end
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign running = (state_q == ST_RUN);
    assign count   = cnt_q;

    p_start_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && cmd_start) |=> (running && count == $past(reload_val)));

    p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick && !cmd_stop && !cmd_force) |=> $stable(count));

    p_zero_reload_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload_val == '0) |=> !running);

    p_stop_halts_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cmd_stop) |=> !running);

endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 24,
    parameter int CALIB_VAL = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              running,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output logic              use_core,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_force,
    output logic [CNT_W-1:0]  reload_val,
    output logic              irq_pulse
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             wr_ctrl, wr_rld, wr_cur, rd_ctrl;
    logic             tickint_q, clksrc_q, flag_q, irq_q;
    logic [CNT_W-1:0] reload_q;
    logic             unused_bits;

    assign idx     = addr[ADDR_W-1:2];
    assign wr_ctrl = wr && (idx == IDX_W'(IDX_CTRL));
    assign wr_rld  = wr && (idx == IDX_W'(IDX_RLD));
    assign wr_cur  = wr && (idx == IDX_W'(IDX_CUR));
    assign rd_ctrl = rd && (idx == IDX_W'(IDX_CTRL));
    assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:CNT_W]};

    assign cmd_start = wr_ctrl && wdata[BIT_EN] && !running;
    assign cmd_stop  = wr_ctrl && !wdata[BIT_EN] && running;
    assign cmd_force = wr_cur ||
                       (wr_ctrl && wdata[BIT_EN] && running && (wdata[BIT_SRC] != clksrc_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tickint_q <= 1'b0;
            clksrc_q  <= 1'b0;
            reload_q  <= '0;
            flag_q    <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                tickint_q <= wdata[BIT_IE];
                clksrc_q  <= wdata[BIT_SRC];
            end
            if (wr_rld) reload_q <= wdata[CNT_W-1:0];
            if (expire)                 flag_q <= 1'b1;
            else if (rd_ctrl || wr_cur) flag_q <= 1'b0;
            irq_q <= expire && tickint_q;
        end
    end

    always_comb begin
        rdata = '0;
        case (idx)
            IDX_W'(IDX_CTRL): begin
                rdata[BIT_EN]   = running;
                rdata[BIT_IE]   = tickint_q;
                rdata[BIT_SRC]  = clksrc_q;
                rdata[BIT_FLAG] = flag_q;
            end
            IDX_W'(IDX_RLD): rdata = DATA_W'(reload_q);
            IDX_W'(IDX_CUR): rdata = running ? DATA_W'(count) : '0;
            IDX_W'(IDX_CAL): rdata = DATA_W'(CALIB_VAL);
            default:         rdata = '0;
        endcase
    end

    assign use_core   = clksrc_q;
    assign reload_val = reload_q;
    assign irq_pulse  = irq_q;

    p_irq_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> flag_q);

    p_irq_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    p_read_clears_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !expire) |=> !flag_q);

    p_force_clears_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur |=> !flag_q);

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 24,
    parameter int CALIB_VAL = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_pulse
);
    logic             tick, use_core, running, expire;
    logic             cmd_start, cmd_stop, cmd_force;
    logic [CNT_W-1:0] count, reload_val;

    tick_timer_src u_src (
        .use_core (use_core),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    tick_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .cmd_force  (cmd_force),
        .reload_val (reload_val),
        .running    (running),
        .count      (count),
        .expire     (expire)
    );

    tick_timer_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CALIB_VAL(CALIB_VAL)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .rd         (reg_rd),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .running    (running),
        .count      (count),
        .expire     (expire),
        .use_core   (use_core),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .cmd_force  (cmd_force),
        .reload_val (reload_val),
        .irq_pulse  (irq_pulse)
    );

endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq_pulse;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    // behavioural reference model
    bit m_en, m_ie, m_src, m_flag, m_irq;
    int m_cnt, m_reload;
    bit tk, exp_now, isctrl, iscur;

    always #10 clk = ~clk;   // 50 MHz

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
            m_cnt = 0; m_reload = 0;
        end else begin
            tk      = m_src ? 1'b1 : ext_tick;
            exp_now = 0;
            isctrl  = reg_wr && reg_addr[3:2] == 2'd0;
            iscur   = reg_wr && reg_addr[3:2] == 2'd2;
            if (isctrl && reg_wdata[0] && !m_en) begin
                m_en = 1; m_cnt = m_reload;
            end else if (isctrl && !reg_wdata[0] && m_en) begin
                m_en = 0;
            end else if (isctrl && m_en && reg_wdata[2] != m_src) begin
                m_cnt = m_reload;
            end else if (iscur) begin
                m_cnt = m_reload;
            end else if (m_en && tk) begin
                if (m_cnt == 0) begin
                    exp_now = 1;
                    m_cnt = m_reload;
                    if (m_reload == 0) m_en = 0;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            m_irq = exp_now && m_ie;
            if (reg_rd && reg_addr[3:2] == 2'd0) m_flag = 0;
            if (iscur) m_flag = 0;
            if (exp_now) m_flag = 1;
            if (isctrl) begin m_ie = reg_wdata[1]; m_src = reg_wdata[2]; end
            if (reg_wr && reg_addr[3:2] == 2'd1) m_reload = int'(reg_wdata & 32'h00FF_FFFF);
        end
    end

    function automatic logic [31:0] exp_read(input logic [1:0] idx);
        case (idx)
            2'd0:    return (32'(m_flag) << 16) | (32'(m_src) << 2) | (32'(m_ie) << 1) | 32'(m_en);
            2'd1:    return 32'(m_reload);
            2'd2:    return m_en ? 32'(m_cnt) : 32'h0;
            default: return 32'd10000;
        endcase
    endfunction

    task automatic compare();
        logic [31:0] e;
        e = exp_read(reg_addr[3:2]);
        checks++;
        if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s: rdata @%0h actual %08h expected %08h", cur_req, reg_addr, reg_rdata, e);
        end
        checks++;
        if (irq_pulse !== m_irq) begin
            fails++;
            $display("FAIL %s: irq_pulse actual %0b expected %0b", cur_req, irq_pulse, m_irq);
        end
    endtask

    task automatic step(input bit wr, input bit rd, input logic [3:0] a,
                        input logic [31:0] d, input bit ext);
        @(negedge clk);
        compare();
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; ext_tick = ext;
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] d);
        step(1'b1, 1'b0, a, d, 1'b0);
    endtask

    // mode 0: no strobe, 1: irregular strobe, 2: strobe every cycle
    task automatic watch(input logic [3:0] a, input int n, input bit rd, input int mode);
        for (int i = 0; i < n; i++) begin
            bit e;
            e = (mode == 2) || (mode == 1 && (i % 3 == 1 || i % 7 == 0));
            step(1'b0, rd, a, 32'h0, e);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        cur_req = "R1";  watch(4'h0, 1, 0, 0); watch(4'h4, 1, 0, 0);
                         watch(4'h8, 1, 0, 0); watch(4'hC, 1, 0, 0);
        cur_req = "R10"; wreg(4'hC, 32'h0); watch(4'hC, 3, 0, 0);
        cur_req = "R13"; wreg(4'h4, 32'hFFFF_FFFF); watch(4'h4, 2, 0, 0);
                         wreg(4'h4, 32'h5); watch(4'h4, 1, 0, 0);
        cur_req = "R2";  wreg(4'h0, 32'hFFFF_0006); watch(4'h0, 2, 0, 0);
        cur_req = "R9";  watch(4'h8, 2, 0, 0); wreg(4'h8, 32'h123); watch(4'h8, 2, 0, 0);
        cur_req = "R3";  wreg(4'h0, 32'h7); watch(4'h8, 14, 0, 0);
        cur_req = "R5";  watch(4'h8, 10, 0, 0);
        cur_req = "R6";  watch(4'h0, 30, 1, 0);
        cur_req = "R11"; watch(4'h8, 3, 0, 0); wreg(4'h0, 32'h3); watch(4'h8, 2, 0, 0);
        cur_req = "R4";  watch(4'h8, 45, 0, 1); watch(4'h0, 4, 0, 1);
        cur_req = "R8";  watch(4'h8, 4, 0, 2); wreg(4'h8, 32'h00AB_CDEF); watch(4'h0, 2, 0, 1);
                         watch(4'h8, 6, 0, 1);
        cur_req = "R12"; wreg(4'h0, 32'h2); watch(4'h8, 12, 0, 2); watch(4'h0, 2, 0, 2);
                         wreg(4'h0, 32'h7); watch(4'h8, 5, 0, 0);
        cur_req = "R7";  wreg(4'h4, 32'h0); watch(4'h0, 10, 0, 0); watch(4'h8, 3, 0, 0);
                         wreg(4'h0, 32'h7); watch(4'h0, 4, 0, 0);
        cur_req = "R5";  wreg(4'h4, 32'h2); wreg(4'h0, 32'h5); watch(4'h8, 12, 0, 0);
                         watch(4'h0, 2, 1, 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule